// File: doc/BRIEF.md
# Dual-Mode DMA Channel Bus Sequencer

This block is the bus engine of one DMA channel. It holds a source address, a destination address and a count of transfer units, and it moves those units over an external bus once the channel is requested and the bus is granted. Two transfer methods are available. The two-cycle method reads the source into an internal holding buffer and then writes that buffer to the destination, which suits memory-to-memory copies. The single-cycle fly-by method touches only the memory side: an acknowledge strobe selects an external I/O device, and that device either takes the data the memory drives or drives the data the memory stores, all in one bus access.

The sequencer drives the address, a read strobe, separate write strobes for even and odd byte addresses, the acknowledge strobe, and a write-data bus with its enable. A 16-bit unit that starts at an odd address, or that travels over an 8-bit external bus, is split into two byte accesses. Each access holds its strobes low for exactly one clock and is followed by a cycle with every strobe high. When the last unit finishes, the channel raises a one-cycle completion pulse and stops.

Top module: `dma_flyby_seq`

## Requirements
- R1: During and straight after reset, rd_n, wr_even_n, wr_odd_n and ack_n are high, and done, busy and bus_wdata_en are low.
- R2: A unit starts only when the remaining count is nonzero and dma_req and bus_grant are both high. Otherwise no strobe goes low. A count loaded as zero produces no access.
- R3: mode_lo[1]=0 selects the two-cycle method and mode_lo[0]=0 selects a 16-bit unit. With an even source and destination on a 16-bit bus (cfg_bus8=0), a unit is one word read at the source (rd_n low) and then one write at the destination with both write strobes low, bus_wdata_en high, and bus_wdata equal to the word read.
- R4: A two-cycle 16-bit unit whose source is odd, or which runs on an 8-bit bus, makes two byte reads at src and src+1. On the 16-bit bus the byte at an odd address is taken from bits 15:8 and the byte at an even address from bits 7:0. On the 8-bit bus every byte comes from bits 7:0.
- R5: A two-cycle 16-bit unit whose destination is odd, or which runs on an 8-bit bus, makes two byte writes at dst (the byte from src) and dst+1 (the byte from src+1). The byte is repeated on both halves of bus_wdata, and the strobe used matches the parity of the address.
- R6: With mode_lo[0]=1 (8-bit unit), a two-cycle unit is one byte read at the source and one byte write at the destination. The write uses wr_even_n for an even address and wr_odd_n for an odd one.
- R7: With mode_lo[1]=1 and mode_hi=0 (memory to I/O), each unit is one access at the source address with rd_n and ack_n low together, both write strobes high and bus_wdata_en low.
- R8: With mode_lo[1]=1 and mode_hi=1 (I/O to memory), each unit is one access at the destination address with ack_n low and rd_n high. Both write strobes are low for a 16-bit unit, the parity-matching strobe alone is low for an 8-bit unit, and bus_wdata_en stays low.
- R9: After each unit the addresses advance by the unit size (1 or 2 bytes). In two-cycle mode both addresses advance. In fly-by mode only the memory-side address advances.
- R10: After the last unit, done is high for exactly one cycle, busy falls, and no further access occurs.
- R11: Every access holds its strobes low for one cycle, and the next cycle has all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load addresses, count and mode (accepted while idle) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Number of transfer units |
| cfg_mode_lo | input | 2 | Bit 1: method (1 fly-by); bit 0: unit (1 byte) |
| cfg_mode_hi | input | 1 | Fly-by direction (1 I/O to memory); 0 in two-cycle mode |
| cfg_bus8 | input | 1 | External bus is 8 bits wide |
| dma_req | input | 1 | Channel request |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_addr | output | AW | Access address |
| bus_rdata | input | 16 | Read data from the external bus |
| bus_wdata | output | 16 | Write data for two-cycle writes |
| bus_wdata_en | output | 1 | bus_wdata is driven |
| rd_n | output | 1 | Read strobe, active low |
| wr_even_n | output | 1 | Even-address write strobe, active low |
| wr_odd_n | output | 1 | Odd-address write strobe, active low |
| ack_n | output | 1 | Fly-by I/O acknowledge, active low |
| busy | output | 1 | Units remain |
| done | output | 1 | One-cycle pulse when the final unit completes |

## Verification
The bench builds the block with a 16-bit address and a 4-bit counter. The small counter keeps every run short, so the bench can sweep each method, unit size, bus width, direction, source parity and destination parity with counts of one to three units. Inside that sweep the access sequence that splitting produces is compared byte by byte against a memory model computed from the address. This covers every split and lane-selection case, the way the addresses carry across units, and the stop after the final unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_t;

  typedef struct packed {
    logic fly;     // single-cycle method
    logic unit8;   // byte-sized unit
    logic io2mem;  // fly-by direction
    logic bus8;    // narrow external bus
  } chan_cfg_t;
endpackage

// File: rtl/dma_acc_plan.sv
module dma_acc_plan
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  chan_cfg_t        cfg,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    dst,
  input  logic [BUS_W-1:0] hold,
  input  logic [1:0]       idx,
  output logic [2:0]       n_acc,
  output logic [AW-1:0]    o_addr,
  output logic             o_rd,
  output logic             o_we_e,
  output logic             o_we_o,
  output logic             o_ack,
  output logic             o_wen,
  output logic [BUS_W-1:0] o_wdata,
  output logic             o_rbyte,
  output logic             o_bsel
);
  logic       split_r, split_w;
  logic [1:0] n_rd, n_wr, wj;
  logic [7:0] wbyte;

  always_comb begin
    split_r = !cfg.unit8 && (src[0] || cfg.bus8);
    split_w = !cfg.unit8 && (dst[0] || cfg.bus8);
    n_rd    = split_r ? 2'd2 : 2'd1;
    n_wr    = split_w ? 2'd2 : 2'd1;
    n_acc   = cfg.fly ? 3'd1 : ({1'b0, n_rd} + {1'b0, n_wr});
    wj      = idx - n_rd;
    wbyte   = wj[0] ? hold[15:8] : hold[7:0];
    o_addr  = src;
    o_rd    = 1'b0;
    o_we_e  = 1'b0;
    o_we_o  = 1'b0;
    o_ack   = 1'b0;
    o_wen   = 1'b0;
    o_wdata = '0;
    o_rbyte = 1'b0;
    o_bsel  = 1'b0;
    if (cfg.fly) begin
      o_addr = cfg.io2mem ? dst : src;
      o_ack  = 1'b1;
      o_rd   = !cfg.io2mem;
      o_we_e = cfg.io2mem && (!cfg.unit8 || !dst[0]);
      o_we_o = cfg.io2mem && (!cfg.unit8 || dst[0]);
    end else if (idx < n_rd) begin
      o_addr  = src + AW'(idx);
      o_rd    = 1'b1;
      o_rbyte = cfg.unit8 || split_r;
      o_bsel  = idx[0];
    end else begin
      o_addr = dst + AW'(wj);
      o_wen  = 1'b1;
      if (cfg.unit8 || split_w) begin
        o_wdata = {wbyte, wbyte};
        o_we_e  = !o_addr[0];
        o_we_o  = o_addr[0];
      end else begin
        o_wdata = hold;
        o_we_e  = 1'b1;
        o_we_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_rd_capture.sv
module dma_rd_capture
  import dma_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             rbyte,
  input  logic             bsel,
  input  logic             addr_lsb,
  input  logic             bus8,
  input  logic [BUS_W-1:0] rdata,
  output logic [BUS_W-1:0] hold
);
  logic [7:0] lane;

  always_comb lane = (bus8 || !addr_lsb) ? rdata[7:0] : rdata[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (cap_en) begin
      if (!rbyte)    hold       <= rdata;
      else if (bsel) hold[15:8] <= lane;
      else           hold[7:0]  <= lane;
    end
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic          unit8,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt
);
  logic [AW-1:0] inc;

  always_comb inc = unit8 ? AW'(1) : AW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= ld_src;
      dst <= ld_dst;
      cnt <= ld_cnt;
    end else if (step) begin
      if (adv_src) src <= src + inc;
      if (adv_dst) dst <= dst + inc;
      cnt <= cnt - CW'(1);
    end
  end

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt != '0)); // R10
endmodule

// File: rtl/dma_flyby_seq.sv
module dma_flyby_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CW-1:0]    cfg_cnt,
  input  logic [1:0]       cfg_mode_lo,
  input  logic             cfg_mode_hi,
  input  logic             cfg_bus8,
  input  logic             dma_req,
  input  logic             bus_grant,
  output logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] bus_wdata,
  output logic             bus_wdata_en,
  output logic             rd_n,
  output logic             wr_even_n,
  output logic             wr_odd_n,
  output logic             ack_n,
  output logic             busy,
  output logic             done
);
  seq_st_t     state;
  chan_cfg_t   cfg_q, cfg_in;
  logic [1:0]  acc_idx, nxt_idx;
  logic        more_q, last, start, cap_en, step, ld_ok;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [BUS_W-1:0] hold;

  logic [2:0]       p_n;
  logic [AW-1:0]    p_addr;
  logic             p_rd, p_we_e, p_we_o, p_ack, p_wen, p_rbyte, p_bsel;
  logic [BUS_W-1:0] p_wdata;

  logic q_rd, q_we_e, q_we_o, q_ack, q_rbyte, q_bsel;

  always_comb begin
    cfg_in  = '{fly: cfg_mode_lo[1], unit8: cfg_mode_lo[0],
                io2mem: cfg_mode_hi, bus8: cfg_bus8};
    busy    = (cnt != '0);
    ld_ok   = cfg_load && (state == ST_IDLE);
    start   = (state == ST_IDLE) && !cfg_load && busy && dma_req && bus_grant;
    nxt_idx = (state == ST_GAP) ? acc_idx + 2'd1 : 2'd0;
    last    = (({1'b0, acc_idx} + 3'd1) == p_n);
    cap_en  = (state == ST_ACC) && q_rd && !cfg_q.fly;
    step    = (state == ST_ACC) && last;
  end

  dma_acc_plan #(.AW(AW)) u_plan (
    .cfg(cfg_q), .src(src), .dst(dst), .hold(hold),
    .idx((state == ST_ACC) ? acc_idx : nxt_idx), .n_acc(p_n),
    .o_addr(p_addr), .o_rd(p_rd), .o_we_e(p_we_e), .o_we_o(p_we_o),
    .o_ack(p_ack), .o_wen(p_wen), .o_wdata(p_wdata),
    .o_rbyte(p_rbyte), .o_bsel(p_bsel)
  );

  dma_rd_capture u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .rbyte(q_rbyte),
    .bsel(q_bsel), .addr_lsb(bus_addr[0]), .bus8(cfg_q.bus8),
    .rdata(bus_rdata), .hold(hold)
  );

  dma_addr_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .load(ld_ok),
    .ld_src(cfg_src), .ld_dst(cfg_dst), .ld_cnt(cfg_cnt),
    .step(step),
    .adv_src(!cfg_q.fly || !cfg_q.io2mem),
    .adv_dst(!cfg_q.fly || cfg_q.io2mem),
    .unit8(cfg_q.unit8),
    .src(src), .dst(dst), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cfg_q        <= '0;
      acc_idx      <= '0;
      more_q       <= 1'b0;
      done         <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_wdata_en <= 1'b0;
      q_rd         <= 1'b0;
      q_we_e       <= 1'b0;
      q_we_o       <= 1'b0;
      q_ack        <= 1'b0;
      q_rbyte      <= 1'b0;
      q_bsel       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ld_ok) cfg_q <= cfg_in;
          if (start) begin
            state        <= ST_ACC;
            acc_idx      <= 2'd0;
            bus_addr     <= p_addr;
            bus_wdata    <= p_wdata;
            bus_wdata_en <= p_wen;
            q_rd         <= p_rd;
            q_we_e       <= p_we_e;
            q_we_o       <= p_we_o;
            q_ack        <= p_ack;
            q_rbyte      <= p_rbyte;
            q_bsel       <= p_bsel;
          end
        end
        ST_ACC: begin
          state        <= ST_GAP;
          more_q       <= !last;
          done         <= last && (cnt == CW'(1));
          bus_wdata_en <= 1'b0;
          q_rd         <= 1'b0;
          q_we_e       <= 1'b0;
          q_we_o       <= 1'b0;
          q_ack        <= 1'b0;
        end
        ST_GAP: begin
          if (more_q) begin
            state        <= ST_ACC;
            acc_idx      <= nxt_idx;
            bus_addr     <= p_addr;
            bus_wdata    <= p_wdata;
            bus_wdata_en <= p_wen;
            q_rd         <= p_rd;
            q_we_e       <= p_we_e;
            q_we_o       <= p_we_o;
            q_ack        <= p_ack;
            q_rbyte      <= p_rbyte;
            q_bsel       <= p_bsel;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_n      = !q_rd;
    wr_even_n = !q_we_e;
    wr_odd_n  = !q_we_o;
    ack_n     = !q_ack;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (rd_n && wr_even_n && wr_odd_n && ack_n)); // R2
  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !(dma_req && bus_grant)) |=> (state != ST_ACC)); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && (!wr_even_n || !wr_odd_n))); // R3
  AST_ACK_FLY_ONLY: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> cfg_q.fly); // R7
  AST_WDATA_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_wdata_en |-> !cfg_q.fly); // R8
  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(rd_n && wr_even_n && wr_odd_n && ack_n) |=> (rd_n && wr_even_n && wr_odd_n && ack_n)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

// File: tb/dma_flyby_seq_bench.sv
`timescale 1ns/1ps
module dma_flyby_seq_bench;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_load, cfg_mode_hi, cfg_bus8, dma_req, bus_grant;
  logic [AW-1:0] cfg_src, cfg_dst, bus_addr;
  logic [CW-1:0] cfg_cnt;
  logic [1:0] cfg_mode_lo;
  logic [15:0] bus_rdata, bus_wdata;
  logic bus_wdata_en, rd_n, wr_even_n, wr_odd_n, ack_n, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  dma_flyby_seq #(.AW(AW), .CW(CW)) u_dma_flyby_seq (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_mode_lo(cfg_mode_lo),
    .cfg_mode_hi(cfg_mode_hi), .cfg_bus8(cfg_bus8), .dma_req(dma_req),
    .bus_grant(bus_grant), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_wdata_en(bus_wdata_en), .rd_n(rd_n),
    .wr_even_n(wr_even_n), .wr_odd_n(wr_odd_n), .ack_n(ack_n),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb
    bus_rdata = cfg_bus8 ? {8'h00, mb(bus_addr)}
                         : {mb(bus_addr | 16'h0001), mb(bus_addr & 16'hFFFE)};

  task automatic check(input bit ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] e_addr [16];
  logic [15:0] e_wd   [16];
  logic [4:0]  e_fl   [16]; // {rd, we_odd, we_even, ack, wen}
  string       e_tag  [16];
  int          e_n;

  task automatic add(input logic [15:0] a, input logic [4:0] fl,
                     input logic [15:0] wd, input string tag);
    e_addr[e_n] = a; e_fl[e_n] = fl; e_wd[e_n] = wd; e_tag[e_n] = tag;
    e_n++;
  endtask

  task automatic build(input bit fly, input bit u8, input bit b8, input bit dir,
                       input logic [15:0] src, input logic [15:0] dst, input int cnt);
    e_n = 0;
    for (int u = 0; u < cnt; u++) begin
      logic [15:0] s, d, a;
      logic [7:0] b0, b1;
      s = src + 16'(u * (u8 ? 1 : 2));
      d = dst + 16'(u * (u8 ? 1 : 2));
      if (fly) begin
        if (dir) begin
          a = d;
          add(a, {1'b0, u8 ? {a[0], !a[0]} : 2'b11, 1'b1, 1'b0}, 16'h0, "R8 R9");
        end else begin
          add(s, 5'b10010, 16'h0, "R7 R9");
        end
      end else if (u8) begin
        b0 = mb(s);
        add(s, 5'b10000, 16'h0, "R6 R9");
        add(d, {1'b0, d[0], !d[0], 1'b0, 1'b1}, {b0, b0}, "R6 R9");
      end else begin
        b0 = mb(s);
        b1 = mb(s + 16'd1);
        if (s[0] || b8) begin
          add(s, 5'b10000, 16'h0, "R4 R9");
          add(s + 16'd1, 5'b10000, 16'h0, "R4 R9");
        end else begin
          add(s, 5'b10000, 16'h0, "R3 R9");
        end
        if (d[0] || b8) begin
          add(d, {1'b0, d[0], !d[0], 1'b0, 1'b1}, {b0, b0}, "R5 R9");
          a = d + 16'd1;
          add(a, {1'b0, a[0], !a[0], 1'b0, 1'b1}, {b1, b1}, "R5 R9");
        end else begin
          add(d, 5'b01101, {b1, b0}, "R3 R9");
        end
      end
    end
  endtask

  task automatic run_case(input bit fly, input bit u8, input bit b8, input bit dir,
                          input logic [15:0] src, input logic [15:0] dst, input int cnt);
    int k;
    bit prev_act, act, got_done;
    logic [4:0] fl;
    build(fly, u8, b8, dir, src, dst, cnt);
    @(negedge clk);
    cfg_load = 1'b1; cfg_src = src; cfg_dst = dst; cfg_cnt = CW'(cnt);
    cfg_mode_lo = {fly, u8}; cfg_mode_hi = dir; cfg_bus8 = b8;
    @(negedge clk);
    cfg_load = 1'b0; dma_req = 1'b1; bus_grant = 1'b1;
    k = 0; prev_act = 1'b0; got_done = 1'b0;
    for (int c = 0; c < 200 && !got_done; c++) begin
      @(negedge clk);
      act = !rd_n || !wr_even_n || !wr_odd_n || !ack_n;
      if (act) begin
        check(!prev_act, "R11", 40'd1, 40'd0);
        fl = {!rd_n, !wr_odd_n, !wr_even_n, !ack_n, bus_wdata_en};
        if (k < e_n) begin
          check(bus_addr == e_addr[k] && fl == e_fl[k] &&
                (!e_fl[k][0] || bus_wdata == e_wd[k]), e_tag[k],
                {bus_addr, bus_wdata, 3'b0, fl},
                {e_addr[k], e_fl[k][0] ? e_wd[k] : bus_wdata, 3'b0, e_fl[k]});
        end else begin
          check(1'b0, "R10 extra access", {bus_addr, 24'd0}, 40'd0);
        end
        k++;
      end
      prev_act = act;
      if (done) got_done = 1'b1;
    end
    check(got_done, "R10 done", {39'd0, got_done}, 40'd1);
    check(k == e_n, "R10 access count", 40'(k), 40'(e_n));
    check(!busy, "R10 busy", {39'd0, busy}, 40'd0);
    dma_req = 1'b0;
    @(negedge clk);
    check(!done, "R10 pulse width", {39'd0, done}, 40'd0);
  endtask

  task automatic quiet_cycles(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(rd_n && wr_even_n && wr_odd_n && ack_n, tag,
            {36'd0, rd_n, wr_even_n, wr_odd_n, ack_n}, 40'hF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_load = 1'b0; cfg_src = '0; cfg_dst = '0; cfg_cnt = '0;
    cfg_mode_lo = 2'b00; cfg_mode_hi = 1'b0; cfg_bus8 = 1'b0;
    dma_req = 1'b0; bus_grant = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_n && wr_even_n && wr_odd_n && ack_n && !done && !busy && !bus_wdata_en,
          "R1 in reset", {33'd0, rd_n, wr_even_n, wr_odd_n, ack_n, done, busy, bus_wdata_en},
          40'h78);
    rst = 1'b0;
    @(negedge clk);
    check(rd_n && wr_even_n && wr_odd_n && ack_n && !done && !busy && !bus_wdata_en,
          "R1 after reset", {33'd0, rd_n, wr_even_n, wr_odd_n, ack_n, done, busy, bus_wdata_en},
          40'h78);

    // R2: request and grant gating, zero count
    cfg_load = 1'b1; cfg_src = 16'h0100; cfg_dst = 16'h0200; cfg_cnt = CW'(2);
    cfg_mode_lo = 2'b00; cfg_mode_hi = 1'b0; cfg_bus8 = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0; dma_req = 1'b1; bus_grant = 1'b0;
    quiet_cycles(6, "R2 no grant");
    dma_req = 1'b0; bus_grant = 1'b1;
    quiet_cycles(6, "R2 no request");
    check(busy, "R2 still pending", {39'd0, busy}, 40'd1);
    dma_req = 1'b1;
    for (int c = 0; c < 60 && busy; c++) @(negedge clk);
    check(!busy, "R2 resumes", {39'd0, busy}, 40'd0);
    dma_req = 1'b0;
    @(negedge clk);
    cfg_load = 1'b1; cfg_cnt = '0;
    @(negedge clk);
    cfg_load = 1'b0; dma_req = 1'b1; bus_grant = 1'b1;
    quiet_cycles(6, "R2 zero count");
    dma_req = 1'b0;

    // two-cycle sweep: R3 R4 R5 R6 R9 R10 R11
    for (int u8 = 0; u8 < 2; u8++)
      for (int b8 = 0; b8 < 2; b8++)
        for (int sp = 0; sp < 2; sp++)
          for (int dp = 0; dp < 2; dp++)
            for (int n = 1; n <= 3; n++)
              run_case(1'b0, u8[0], b8[0], 1'b0, 16'h0140 + 16'(sp),
                       16'h0380 + 16'(dp), n);

    // fly-by sweep: R7 R8 R9 R10 R11
    for (int dir = 0; dir < 2; dir++)
      for (int u8 = 0; u8 < 2; u8++)
        for (int p = 0; p < 2; p++)
          for (int n = 1; n <= 3; n++)
            run_case(1'b1, u8[0], 1'b0, dir[0], 16'h0520 + 16'(p),
                     16'h07F0 + 16'(p), n);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule